// File: doc/BRIEF.md
# Timing-Guarded Supply Voltage Selector

This block picks a supply-voltage code and an operating frequency for one processing unit in a datapath that switches between several communication standards. A 2-bit standard selector chooses the unit's clock frequency from a fixed table. The unit reports its measured power and its measured worst-case path delay at the present supply level, marked by a single-cycle valid strobe.

On each strobe the block makes one decision. If the clock period is too short for the reported delay, the unit cannot produce correct data. In that case the block forces the highest supply code, because saving the data is worth more than trimming voltage. Otherwise the code comes from a small parameter table, which holds a precomputed fuzzy decision. The table is indexed by the clipped power error and the active standard.

The delay test avoids a divider. It multiplies the frequency in MHz by the delay in ns and compares the product with 1000. When the standard changes, the delay feedback no longer matches the new frequency. The block then goes to the highest code until a fresh strobe arrives.

Top module: `vsel_guard`

## Requirements
- R1: While reset is asserted, `vdd_code` is 15, which is the highest code. `freq_mhz` is 10, the table entry for standard 0.
- R2: `freq_mhz` shows the frequency of the standard on `std_sel` one clock later. The mapping is 0→10, 1→50, 2→100 and 3→200 MHz.
- R3: Take a strobe with the standard unchanged. If `freq_mhz` × `fb_tmax` ≥ 1000, `vdd_code` becomes 15 on the next clock. An exact product of 1000 also gives 15.
- R4: Take a strobe with the standard unchanged. If the product is below 1000, `vdd_code` becomes the table entry at a 5-bit address. Bits [4:2] hold the power error in two's complement. Bits [1:0] hold the active standard. Entry i sits at bits [4i+3:4i] of the table parameter.
- R5: The power error is `fb_power` − `target_pwr`, taken as a signed value and clipped to the range −4 to +3.
- R6: With no strobe and no change of standard, `vdd_code` keeps its value, whatever the feedback inputs carry.
- R7: In a clock where `std_sel` differs from the active standard, `vdd_code` becomes 15 and any strobe in that clock is ignored. The next strobe decides normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| std_sel | input | 2 | Selected communication standard |
| fb_valid | input | 1 | Feedback valid strobe |
| fb_power | input | 8 | Measured power of the unit |
| fb_tmax | input | 8 | Measured worst-case delay in ns |
| target_pwr | input | 8 | Power target |
| vdd_code | output | 4 | Registered supply-voltage code, 15 is the highest |
| freq_mhz | output | 8 | Registered unit frequency in MHz |

## Verification
The assertions check four behaviours on every clock:
- the code holds between strobes;
- a change of standard forces the highest code;
- the frequency stays stable while the standard stays the same;
- any strobe whose frequency-delay product reaches 1000 leads to the highest code.

The table lookup itself, and the clipping of the power error into the address, are shown only by the bench. It sweeps every address for every standard and compares each result with its own copy of the table. The two worked frequency and delay examples and both exact-equality products are likewise shown by bench scenarios.

// File: rtl/vsel_guard.sv
module vsel_guard #(
  parameter int FW    = 8,
  parameter int TW    = 8,
  parameter int PW    = 8,
  parameter int VW    = 4,
  parameter int SW    = 2,
  parameter int EW    = 3,
  parameter int LIMIT = 1000,
  parameter logic [(1<<SW)*FW-1:0] FTAB = {8'd200, 8'd100, 8'd50, 8'd10},
  parameter logic [(1<<(EW+SW))*VW-1:0] ROM = 128'h0123_4567_89AB_CDEE_EDCB_A987_6543_2101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] std_sel,
  input  logic          fb_valid,
  input  logic [PW-1:0] fb_power,
  input  logic [TW-1:0] fb_tmax,
  input  logic [PW-1:0] target_pwr,
  output logic [VW-1:0] vdd_code,
  output logic [FW-1:0] freq_mhz
);
  localparam int AW   = EW + SW;
  localparam int MW   = FW + TW;
  localparam int EMAX = (1 << (EW - 1)) - 1;
  localparam int EMIN = -(1 << (EW - 1));
  localparam logic [VW-1:0] VMAX = {VW{1'b1}};

  logic [SW-1:0] std_q;
  logic [FW-1:0] f_cur, f_next;
  logic [MW-1:0] prod;
  logic signed [PW:0] diff;
  logic [EW-1:0] perr;
  logic [AW-1:0] addr;
  logic [VW-1:0] rom_v;
  logic std_chg, too_slow;

  assign std_chg  = std_sel != std_q;
  assign f_cur    = FTAB[int'(std_q) * FW +: FW];
  assign f_next   = FTAB[int'(std_sel) * FW +: FW];
  assign prod     = {{TW{1'b0}}, f_cur} * {{FW{1'b0}}, fb_tmax};
  assign too_slow = prod >= MW'(LIMIT);
  assign diff     = $signed({1'b0, fb_power}) - $signed({1'b0, target_pwr});
  assign perr     = (diff > EMAX) ? EW'(EMAX) :
                    (diff < EMIN) ? EW'(EMIN) : diff[EW-1:0];
  assign addr     = {perr, std_q};
  assign rom_v    = ROM[int'(addr) * VW +: VW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      std_q    <= '0;
      freq_mhz <= FTAB[FW-1:0];
      vdd_code <= VMAX;
    end else begin
      std_q    <= std_sel;
      freq_mhz <= f_next;
      if (std_chg)
        vdd_code <= VMAX;
      else if (fb_valid)
        vdd_code <= too_slow ? VMAX : rom_v;
    end
  end
endmodule

// File: rtl/vsel_guard_chk.sv
module vsel_guard_chk #(
  parameter int FW = 8,
  parameter int TW = 8,
  parameter int VW = 4,
  parameter int SW = 2,
  parameter int LIMIT = 1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fb_valid,
  input logic [SW-1:0] std_sel,
  input logic [SW-1:0] std_q,
  input logic [TW-1:0] fb_tmax,
  input logic [FW-1:0] freq_mhz,
  input logic [VW-1:0] vdd_code
);
  localparam logic [VW-1:0] VMAX = {VW{1'b1}};

  a_r1_reset_max: assert property (@(posedge clk) !rst_n |=> vdd_code == VMAX);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fb_valid && std_sel == std_q) |=> $stable(vdd_code));

  a_r7_change_max: assert property (@(posedge clk) disable iff (!rst_n)
    (std_sel != std_q) |=> vdd_code == VMAX);

  a_r2_freq_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (std_sel == std_q) |=> $stable(freq_mhz));

  a_r3_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_valid && std_sel == std_q &&
     ({{TW{1'b0}}, freq_mhz} * {{FW{1'b0}}, fb_tmax}) >= (FW+TW)'(LIMIT))
    |=> vdd_code == VMAX);
endmodule

bind vsel_guard vsel_guard_chk #(.FW(FW), .TW(TW), .VW(VW), .SW(SW), .LIMIT(LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .fb_valid(fb_valid), .std_sel(std_sel), .std_q(std_q),
  .fb_tmax(fb_tmax), .freq_mhz(freq_mhz), .vdd_code(vdd_code));

// File: tb/sim_vsel_guard.sv
`timescale 1ns/1ps
module sim_vsel_guard;
  function automatic logic [127:0] mk_rom();
    logic [127:0] r;
    for (int a = 0; a < 32; a++) r[a*4 +: 4] = 4'((a * 5 + 2) % 15);
    return r;
  endfunction
  localparam logic [127:0] TROM = mk_rom();

  logic clk = 0, rst_n = 0, fb_valid = 0;
  logic [1:0] std_sel = 0;
  logic [7:0] fb_power = 0, fb_tmax = 0, target_pwr = 100;
  logic [3:0] vdd_code;
  logic [7:0] freq_mhz;
  int errors = 0, checks = 0;
  bit done = 0;

  logic [3:0] qv[$];
  logic [7:0] qf[$];
  string qt[$];
  int cur_std = 0;
  logic [3:0] last_v = 4'd15;

  always #2.5 clk = ~clk;

  vsel_guard #(.ROM(TROM)) u0 (.clk(clk), .rst_n(rst_n), .std_sel(std_sel), .fb_valid(fb_valid),
    .fb_power(fb_power), .fb_tmax(fb_tmax), .target_pwr(target_pwr),
    .vdd_code(vdd_code), .freq_mhz(freq_mhz));

  function automatic int ft(int s);
    case (s) 0: return 10; 1: return 50; 2: return 100; default: return 200; endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, int s, int pwr, int tmax, string tag);
    int e, ev, a;
    @(negedge clk);
    fb_valid = v; std_sel = 2'(s); fb_power = 8'(pwr); fb_tmax = 8'(tmax);
    if (s != cur_std) begin ev = 15; cur_std = s; end
    else if (v) begin
      if (ft(cur_std) * tmax >= 1000) ev = 15;
      else begin
        e = pwr - int'(target_pwr);
        if (e > 3) e = 3;
        if (e < -4) e = -4;
        a = ((e & 7) << 2) | cur_std;
        ev = int'(TROM[a*4 +: 4]);
      end
    end else ev = int'(last_v);
    last_v = 4'(ev);
    qv.push_back(4'(ev)); qf.push_back(8'(ft(s))); qt.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (qv.size() > 0) begin
      string t;
      t = qt.pop_front();
      chk({t, " vdd"}, int'(vdd_code), int'(qv.pop_front()));
      chk({"R2 freq ", t}, int'(freq_mhz), int'(qf.pop_front()));
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset vdd", int'(vdd_code), 15);
    chk("R1 reset freq", int'(freq_mhz), 10);
    rst_n = 1;
    step(0, 0, 0, 0, "R6 idle");
    step(1, 0, 100, 16, "R4 10MHz 16ns table");
    step(0, 0, 255, 255, "R6 hold after table");
    step(1, 3, 100, 1, "R7 change ignores strobe");
    step(1, 3, 101, 1, "R4 200MHz short delay");
    step(1, 3, 100, 16, "R3 200MHz 16ns max");
    step(1, 1, 100, 1, "R7 change to 50MHz");
    step(1, 1, 100, 19, "R4 product 950");
    step(1, 1, 100, 20, "R3 product 1000 equal");
    step(1, 2, 99, 9, "R7 change to 100MHz");
    step(1, 2, 99, 9, "R4 product 900");
    step(1, 2, 99, 10, "R3 product 1000 equal");
    step(0, 2, 0, 0, "R6 hold max");
    step(1, 2, 255, 1, "R5 clip high");
    step(1, 2, 0, 1, "R5 clip low");
    step(0, 2, 100, 1, "R6 hold feedback change");
    for (int s = 0; s < 4; s++) begin
      step(0, (s + 1) % 4, 100, 1, "R7 sweep change");
      step(0, s, 100, 1, "R7 sweep change back");
      for (int e = -6; e <= 5; e++) step(1, s, 100 + e, 1, "R4 R5 sweep");
    end
    @(negedge clk); fb_valid = 0;
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule